// File: doc/BRIEF.md
# Framed Serial Byte Receiver with Receive FIFO

This block is the receive half of a serial audio codec link. It watches a bit clock that has been brought into the system clock domain. On every high-to-low transition of that clock it takes one bit from the serial data line. A frame sync pulse that is high during the first bit of a frame marks where each byte starts. Bits are shifted in most significant bit first. Once eight bits have arrived, the byte is pushed into a receive FIFO. Software drains the FIFO through a simple read strobe.

The block reports empty and full flags, a sticky overflow flag, a receive interrupt at half occupancy, an interrupt output that merges in the transmit side's request, and a busy indication. When reception is turned off, a byte already in progress is still completed before the receiver goes idle. A loopback select makes the receiver take its bits from the transmitter's serial output instead of the external pin, for system self test.

Top module: `rx_codec_receiver`

## Requirements
- R1: A bit is captured in the system clock cycle where `bitClk` is first seen low after being high. The captured value is the selected serial input in that same cycle. A completed byte is visible at `rdData` one clock after the cycle of its eighth captured bit.
- R2: A capture with `frameSync` high while `rxEnable` is high starts a new byte with that bit as the MSB and discards any partial byte. Captures while no byte is in progress and no frame start is seen are ignored.
- R3: Bits fill the byte MSB first. `rdData` shows the oldest stored byte. `rdEn` removes it when the FIFO is not empty. `fifoEmpty` is high with 0 bytes stored and `fifoFull` is high with 16 bytes stored.
- R4: A byte that completes while the FIFO holds 16 bytes is dropped, even if a read happens in the same cycle, and `overflow` goes high on the next clock.
- R5: `rxIrq` is high exactly when the FIFO holds 8 or more bytes.
- R6: `anyIrq` equals `rxIrq` OR `txIrq`.
- R7: Clearing `rxEnable` during a byte lets that byte complete and be stored. No new byte starts while `rxEnable` is low.
- R8: `rxBusy` is high while `rxEnable` is high or a byte is in progress. After a disable, it falls in the same cycle that the final byte appears in the FIFO.
- R9: With `loopEn` at 1 the receiver samples `txSerData`, and `serDataIn` has no effect. With `loopEn` at 0 it samples `serDataIn`.
- R10: `overflow` is cleared one clock after a `statusRd` pulse. If a drop happens in the same cycle, the set takes priority. Reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitClk | input | 1 | Serial bit clock, already synchronised to `clk` |
| frameSync | input | 1 | High during the first bit of a frame |
| serDataIn | input | 1 | External serial data |
| txSerData | input | 1 | Transmitter serial output, used as the loopback source |
| loopEn | input | 1 | 1 selects loopback |
| rxEnable | input | 1 | Reception enable |
| rdEn | input | 1 | Pops the oldest FIFO byte |
| statusRd | input | 1 | Status read strobe; clears overflow |
| txIrq | input | 1 | Transmit interrupt request to merge |
| rdData | output | 8 | Oldest FIFO byte |
| fifoEmpty | output | 1 | FIFO holds no bytes |
| fifoFull | output | 1 | FIFO holds 16 bytes |
| rxIrq | output | 1 | FIFO holds at least half its capacity |
| anyIrq | output | 1 | OR of receive and transmit interrupts |
| rxBusy | output | 1 | Receiver enabled or finishing a byte |
| overflow | output | 1 | Sticky dropped-byte flag |

## Verification
Register-driven results appear one clock after the cycle that causes them. The FIFO flags, `rdData` and `rxIrq` change one clock after the eighth capture or the read. `overflow` changes one clock after a drop or a status read. `rxBusy` and `anyIrq` follow `rxEnable` and `txIrq` in the same cycle. The bench model applies each clock's inputs at the rising edge, then compares every output a quarter period later, while the inputs driven on the falling edge are still steady. Each comparison therefore sees the registered results of exactly the edge just taken.

// File: rtl/rx_pkg.sv
package rx_pkg;
  typedef struct packed {
    logic startFrame;  // capture that opens a new byte
    logic shiftBit;    // capture that extends the current byte
    logic pushByte;    // this capture completes the byte
  } rxStrobe_t;
endpackage

// File: rtl/rx_frame_ctrl.sv
module rx_frame_ctrl
  import rx_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitClk,
  input  logic       frameSync,
  input  logic       rxEnable,
  output rxStrobe_t  strobe,
  output logic       frameActive
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic             bitClkPrev;
  logic [CNT_W-1:0] bitCnt;
  logic             fallEdge;

  assign fallEdge = bitClkPrev && !bitClk;

  always_comb begin
    strobe.startFrame = fallEdge && frameSync && rxEnable;
    strobe.shiftBit   = fallEdge && frameActive && !strobe.startFrame;
    strobe.pushByte   = strobe.shiftBit && (bitCnt == CNT_W'(BYTE_W - 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitClkPrev  <= 1'b0;
      bitCnt      <= '0;
      frameActive <= 1'b0;
    end else begin
      bitClkPrev <= bitClk;
      if (strobe.startFrame) begin
        frameActive <= 1'b1;
        bitCnt      <= CNT_W'(1);
      end else if (strobe.pushByte) begin
        frameActive <= 1'b0;
        bitCnt      <= '0;
      end else if (strobe.shiftBit) begin
        bitCnt <= bitCnt + CNT_W'(1);
      end
    end
  end

  // R7: while disabled and idle, no byte may begin
  a_r7_no_start_when_off: assert property (@(posedge clk) disable iff (!rstN)
    (!rxEnable && !frameActive) |=> !frameActive);

  // R2: a byte only ends by being pushed (or being restarted)
  a_r2_end_by_push: assert property (@(posedge clk) disable iff (!rstN)
    $fell(frameActive) |-> $past(strobe.pushByte));

  // R1: start and extend never coincide
  a_r1_strobe_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.startFrame, strobe.shiftBit}));
endmodule

// File: rtl/rx_fifo_path.sv
module rx_fifo_path
  import rx_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         strobe,
  input  logic              serBit,
  input  logic              rdEn,
  input  logic              statusRd,
  output logic [BYTE_W-1:0] rdData,
  output logic              fifoEmpty,
  output logic              fifoFull,
  output logic              rxIrq,
  output logic              overflow
);
  localparam int AW    = $clog2(DEPTH);
  localparam int CNT_W = AW + 1;

  logic [BYTE_W-1:0] shiftReg;
  logic [BYTE_W-1:0] nextByte;
  logic [BYTE_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;
  logic              doWrite, doRead, dropByte;

  assign nextByte  = {shiftReg[BYTE_W-2:0], serBit};
  assign fifoEmpty = (count == '0);
  assign fifoFull  = (count == CNT_W'(DEPTH));
  assign rxIrq     = (count >= CNT_W'(DEPTH / 2));
  assign doWrite   = strobe.pushByte && !fifoFull;
  assign dropByte  = strobe.pushByte && fifoFull;
  assign doRead    = rdEn && !fifoEmpty;
  assign rdData    = mem[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strobe.startFrame) begin
      shiftReg <= {{(BYTE_W-1){1'b0}}, serBit};
    end else if (strobe.shiftBit) begin
      shiftReg <= nextByte;
    end
  end

  always_ff @(posedge clk) begin
    if (doWrite) mem[wrPtr] <= nextByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (doWrite) wrPtr <= wrPtr + AW'(1);
      if (doRead)  rdPtr <= rdPtr + AW'(1);
      case ({doWrite, doRead})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
      if (dropByte)      overflow <= 1'b1;
      else if (statusRd) overflow <= 1'b0;
    end
  end

  a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(fifoEmpty && fifoFull));

  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  a_r4_drop_sets_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pushByte && fifoFull) |=> overflow);

  a_r10_clear_on_read: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd && !(strobe.pushByte && fifoFull)) |=> !overflow);
endmodule

// File: rtl/rx_codec_receiver.sv
module rx_codec_receiver
  import rx_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitClk,
  input  logic              frameSync,
  input  logic              serDataIn,
  input  logic              txSerData,
  input  logic              loopEn,
  input  logic              rxEnable,
  input  logic              rdEn,
  input  logic              statusRd,
  input  logic              txIrq,
  output logic [BYTE_W-1:0] rdData,
  output logic              fifoEmpty,
  output logic              fifoFull,
  output logic              rxIrq,
  output logic              anyIrq,
  output logic              rxBusy,
  output logic              overflow
);
  rxStrobe_t strobe;
  logic      frameActive;
  logic      serBit;

  assign serBit = loopEn ? txSerData : serDataIn;
  assign rxBusy = rxEnable || frameActive;
  assign anyIrq = rxIrq || txIrq;

  rx_frame_ctrl #(.BYTE_W(BYTE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .bitClk(bitClk), .frameSync(frameSync),
    .rxEnable(rxEnable), .strobe(strobe), .frameActive(frameActive)
  );

  rx_fifo_path #(.BYTE_W(BYTE_W), .DEPTH(DEPTH)) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .serBit(serBit),
    .rdEn(rdEn), .statusRd(statusRd), .rdData(rdData),
    .fifoEmpty(fifoEmpty), .fifoFull(fifoFull), .rxIrq(rxIrq),
    .overflow(overflow)
  );

  // R8: busy may only drop on the cycle the last byte is taken
  a_r8_busy_until_push: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(rxBusy) && !$fell(rxEnable)) |-> $past(strobe.pushByte));
endmodule

// File: tb/rx_codec_receiver_tb.sv
module rx_codec_receiver_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitClk = 1'b0, frameSync = 1'b0, serDataIn = 1'b0, txSerData = 1'b0;
  logic loopEn = 1'b0, rxEnable = 1'b0, rdEn = 1'b0, statusRd = 1'b0, txIrq = 1'b0;
  logic [7:0] rdData;
  logic fifoEmpty, fifoFull, rxIrq, anyIrq, rxBusy, overflow;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  string phase = "reset R3";

  rx_codec_receiver u_dut (
    .clk(clk), .rstN(rstN), .bitClk(bitClk), .frameSync(frameSync),
    .serDataIn(serDataIn), .txSerData(txSerData), .loopEn(loopEn),
    .rxEnable(rxEnable), .rdEn(rdEn), .statusRd(statusRd), .txIrq(txIrq),
    .rdData(rdData), .fifoEmpty(fifoEmpty), .fifoFull(fifoFull),
    .rxIrq(rxIrq), .anyIrq(anyIrq), .rxBusy(rxBusy), .overflow(overflow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference state
  logic [7:0] mq[$];
  logic mPrev = 1'b0;
  logic mAct = 1'b0;
  logic mOvf = 1'b0;
  int   mCnt = 0;
  int   mSh = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s [%s] actual=%0h expected=%0h t=%0t", tag, phase, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    logic fall, b, push, wasFull;
    if (!rstN) begin
      mq.delete(); mPrev = 1'b0; mAct = 1'b0; mOvf = 1'b0; mCnt = 0; mSh = 0;
    end else begin
      fall = mPrev && !bitClk;
      mPrev = bitClk;
      b = loopEn ? txSerData : serDataIn;
      push = 1'b0;
      wasFull = (mq.size() == DEPTH);
      if (fall) begin
        if (frameSync && rxEnable) begin
          mSh = int'(b); mCnt = 1; mAct = 1'b1;
        end else if (mAct) begin
          mSh = ((mSh << 1) | int'(b)) & 255;
          mCnt++;
          if (mCnt == 8) begin push = 1'b1; mAct = 1'b0; mCnt = 0; end
        end
      end
      if (statusRd) mOvf = 1'b0;
      if (rdEn && mq.size() > 0) void'(mq.pop_front());
      if (push) begin
        if (wasFull) mOvf = 1'b1;
        else mq.push_back(mSh[7:0]);
      end
    end
    #(CLK_PERIOD/4);
    chk("R3 empty", int'(fifoEmpty), int'(mq.size() == 0));
    chk("R3 full", int'(fifoFull), int'(mq.size() == DEPTH));
    if (mq.size() > 0) chk("R1 R3 rdData", int'(rdData), int'(mq[0]));
    chk("R5 rxIrq", int'(rxIrq), int'(mq.size() >= 8));
    chk("R6 anyIrq", int'(anyIrq), int'((mq.size() >= 8) || txIrq));
    chk("R8 rxBusy", int'(rxBusy), int'(rxEnable || mAct));
    chk("R4 R10 overflow", int'(overflow), int'(mOvf));
  end

  // one bit period of four clocks; capture on the first low cycle
  task automatic sendBit(input logic v, input logic sync, input logic viaLoop);
    @(negedge clk); bitClk = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bitClk = 1'b0; frameSync = sync;
    if (viaLoop) begin txSerData = v; serDataIn = ~v; end
    else begin serDataIn = v; txSerData = ~v; end
    @(negedge clk); frameSync = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] v, input logic viaLoop);
    for (int i = 7; i >= 0; i--) sendBit(v[i], i == 7, viaLoop);
  endtask

  task automatic readOne();
    @(negedge clk); rdEn = 1'b1;
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic drain();
    while (!fifoEmpty) readOne();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    rxEnable = 1'b1;

    phase = "R1 R3 basic";
    sendByte(8'hA5, 1'b0);
    sendByte(8'h3C, 1'b0);
    readOne();
    readOne();

    phase = "R2 resync";
    for (int i = 0; i < 3; i++) sendBit(1'b1, i == 0, 1'b0);
    sendByte(8'h5A, 1'b0);
    for (int i = 0; i < 10; i++) sendBit(i[0], 1'b0, 1'b0); // no sync: ignored
    drain();

    phase = "R4 R5 R6 fill";
    txIrq = 1'b1;
    for (int i = 0; i < 3; i++) sendByte(8'(i * 17 + 1), 1'b0);
    txIrq = 1'b0;
    for (int i = 3; i < DEPTH + 2; i++) sendByte(8'(i * 17 + 1), 1'b0);
    phase = "R10 clear";
    @(negedge clk); statusRd = 1'b1;
    @(negedge clk); statusRd = 1'b0;
    readOne();
    drain();

    phase = "R7 R8 disable";
    for (int i = 7; i >= 0; i--) begin
      sendBit(i[0], i == 7, 1'b0);
      if (i == 5) rxEnable = 1'b0;
    end
    sendByte(8'hF0, 1'b0); // disabled: must not be stored
    repeat (4) @(negedge clk);
    drain();

    phase = "R9 loopback";
    rxEnable = 1'b1;
    loopEn = 1'b1;
    sendByte(8'hC3, 1'b1);
    loopEn = 1'b0;
    sendByte(8'h81, 1'b0);
    drain();
    repeat (4) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule